// File: doc/BRIEF.md
# Serial Link Write Packet Framer

This block sits on the transmit side of a narrow point-to-point serial link that moves memory writes between two chips. It pops write commands (start address and word count) from a command queue and write words with per-byte enables from a data queue. It turns them into a stream of 8-bit symbols. Each symbol is flagged as a plain data byte or as a control (K) code group, and an external 8b/10b encoder consumes the stream. Packets are delimited in band: there is no fixed frame length. A packet opens with a command byte and closes with a single end-of-packet control symbol, and the link carries idle symbols whenever no packet is under way.

The symbol order does not depend on how many serial lanes (one to four) the serializer later drives. Two link-control inputs act on the stream. A remote-hold input pauses an outbound burst, which resumes later exactly where it stopped. A local-full input reports the state of this side's receive buffer; each change of it becomes one flow-control start or stop symbol, inserted ahead of any pending packet symbol.

Top module: `lnk_tx_framer`

## Requirements
- R1: While reset is asserted, and until the first symbol is loaded, `sym_valid`, `cmd_ready` and `wdat_ready` are 0.
- R2: With no command pending, no hold and no flow-control change, every symbol offered is the idle control symbol (K, 0xBC).
- R3: A packet starts with a data byte holding the packet type in bits 7:4 and zero in bits 3:0. The type is 0011 (single 32-bit word write) when `cmd_nwords_m1` is 0, otherwise 0001 (incrementing write), and the 0001 form is followed by one data byte equal to 4*(words) - 1.
- R4: The address follows as four data bytes, most significant byte first.
- R5: Each write word follows as four symbols, most significant byte first.
- R6: A byte whose enable bit is 0 is replaced by the byte-disable control symbol (K, 0xF7). Bit 3 of `wdat_be` covers the first (most significant) byte.
- R7: Each packet ends with exactly one end-of-packet control symbol (K, 0xFD), and the next command byte comes only after it.
- R8: While `sym_valid` is high and `sym_ready` is low, `sym_data` and `sym_is_k` hold their values; no symbol is dropped or repeated.
- R9: While `rmt_hold` is high, only idle symbols (or flow-control symbols) are emitted, no command or word is taken, and the packet resumes intact afterwards.
- R10: Each rise of `loc_full` yields exactly one flow-control start symbol (K, 0x1C) and each fall exactly one stop symbol (K, 0x7C).
- R11: If the next write word is not yet available, idle symbols fill the gap and the packet continues without losing or reordering bytes.
- R12: A pending flow-control symbol wins over idle, hold and packet symbols, and it is inserted between packet symbols without disturbing the packet content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command available |
| cmd_ready | output | 1 | Command taken this cycle when valid |
| cmd_addr | input | 32 | Start address of the write |
| cmd_nwords_m1 | input | 6 | Number of write words minus one |
| wdat_valid | input | 1 | Write word available |
| wdat_ready | output | 1 | Write word taken this cycle when valid |
| wdat_data | input | 32 | Write word |
| wdat_be | input | 4 | Byte enables, bit 3 = most significant byte |
| rmt_hold | input | 1 | Remote side asks for a pause |
| loc_full | input | 1 | Local receive buffer full |
| sym_valid | output | 1 | Symbol offered |
| sym_ready | input | 1 | Encoder accepts the symbol |
| sym_data | output | 8 | Symbol byte |
| sym_is_k | output | 1 | 1 = control code group |

## Verification
The next symbol is chosen combinationally in the cycle of a handshake and appears on the output register one edge later. The bench therefore drives every input at the falling edge and treats a symbol seen with `sym_ready` high as consumed at the following rising edge. The hold rule is checked against the hold value driven one falling edge earlier, with `sym_ready` kept high so that every edge loads a symbol. Stall stability is checked one cycle after each refused symbol. Packet content is compared as an ordered stream of non-idle symbols, so gaps from holds, data underflow and inserted flow-control symbols do not shift the expected positions.

// File: rtl/tx_link_pkg.sv
package tx_link_pkg;

  // control code group byte values (K flag set)
  localparam logic [7:0] K_IDLE  = 8'hBC;
  localparam logic [7:0] K_EOP   = 8'hFD;
  localparam logic [7:0] K_MASK  = 8'hF7;
  localparam logic [7:0] K_FCON  = 8'h1C;
  localparam logic [7:0] K_FCOFF = 8'h7C;
  localparam logic [7:0] K_ERR   = 8'hFE;
  localparam logic [7:0] K_INIT0 = 8'h3C;
  localparam logic [7:0] K_INIT1 = 8'h5C;
  localparam logic [7:0] K_LINK  = 8'h9C;

  // packet type codes (header bits 7:4)
  localparam logic [3:0] PT_WR_INC = 4'b0001;
  localparam logic [3:0] PT_WR32   = 4'b0011;

  typedef struct packed {
    logic       k;
    logic [7:0] d;
  } sym_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_BCNT = 3'd1,
    S_ADDR = 3'd2,
    S_DATA = 3'd3,
    S_EOP  = 3'd4
  } seq_st_e;

endpackage

// File: rtl/tx_fc_notify.sv
module tx_fc_notify
  import tx_link_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic loc_full,
  input  logic take,
  output logic req,
  output sym_t sym_o
);

  logic told_q;
  logic told_d;

  // a request is open while the remote has not yet been told the current state
  always_comb begin
    req        = loc_full ^ told_q;
    sym_o.k    = 1'b1;
    sym_o.d    = loc_full ? K_FCON : K_FCOFF;
    told_d     = told_q;
    if (take && req) begin
      told_d = loc_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      told_q <= 1'b0;
    end else begin
      told_q <= told_d;
    end
  end

  AST_FC_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req) |=> (!req || !$stable(loc_full)));  // R10

endmodule

// File: rtl/tx_pkt_seq.sv
module tx_pkt_seq
  import tx_link_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [LEN_W-1:0]    cmd_nwm1,
  input  logic                wdat_valid,
  output logic                wdat_ready,
  input  logic [DATA_W-1:0]   wdat_data,
  input  logic [DATA_W/8-1:0] wdat_be,
  output sym_t                sym_o
);

  localparam int ABYTES = ADDR_W / 8;
  localparam int DBYTES = DATA_W / 8;
  localparam int MAXB   = (ABYTES > DBYTES) ? ABYTES : DBYTES;
  localparam int IDX_W  = $clog2(MAXB + 1);

  seq_st_e             st_q, st_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [LEN_W-1:0]    nwm1_q, nwm1_d;
  logic [LEN_W-1:0]    wcnt_q, wcnt_d;
  logic [IDX_W-1:0]    bidx_q, bidx_d;
  logic [DATA_W-1:0]   word_q, word_d;
  logic [DBYTES-1:0]   be_q, be_d;

  logic [DATA_W-1:0]   cur_word;
  logic [DBYTES-1:0]   cur_be;
  logic                have_word;
  logic                last_a;
  logic                last_d;
  logic [ADDR_W-1:0]   addr_sh;
  logic [DATA_W-1:0]   word_sh;
  logic [DBYTES-1:0]   be_sh;
  logic [7:0]          bcnt;

  always_comb begin
    cur_word  = (bidx_q == '0) ? wdat_data : word_q;
    cur_be    = (bidx_q == '0) ? wdat_be   : be_q;
    have_word = (bidx_q != '0) || wdat_valid;
    last_a    = (bidx_q == IDX_W'(ABYTES - 1));
    last_d    = (bidx_q == IDX_W'(DBYTES - 1));
    addr_sh   = addr_q   >> (8 * (ABYTES - 1 - int'(bidx_q)));
    word_sh   = cur_word >> (8 * (DBYTES - 1 - int'(bidx_q)));
    be_sh     = cur_be   >> (DBYTES - 1 - int'(bidx_q));
    bcnt      = 8'((32'(nwm1_q) + 32'd1) * DBYTES - 1);
  end

  // next-state and symbol selection
  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    nwm1_d     = nwm1_q;
    wcnt_d     = wcnt_q;
    bidx_d     = bidx_q;
    word_d     = word_q;
    be_d       = be_q;
    cmd_ready  = 1'b0;
    wdat_ready = 1'b0;
    sym_o.k    = 1'b1;
    sym_o.d    = K_IDLE;
    unique case (st_q)
      S_IDLE: begin
        cmd_ready = go;
        if (cmd_valid) begin
          sym_o.k = 1'b0;
          sym_o.d = {(cmd_nwm1 == '0) ? PT_WR32 : PT_WR_INC, 4'h0};
          if (go) begin
            addr_d = cmd_addr;
            nwm1_d = cmd_nwm1;
            wcnt_d = '0;
            bidx_d = '0;
            st_d   = (cmd_nwm1 == '0) ? S_ADDR : S_BCNT;
          end
        end
      end
      S_BCNT: begin
        sym_o.k = 1'b0;
        sym_o.d = bcnt;
        if (go) begin
          st_d = S_ADDR;
        end
      end
      S_ADDR: begin
        sym_o.k = 1'b0;
        sym_o.d = addr_sh[7:0];
        if (go) begin
          if (last_a) begin
            st_d   = S_DATA;
            bidx_d = '0;
          end else begin
            bidx_d = bidx_q + 1'b1;
          end
        end
      end
      S_DATA: begin
        wdat_ready = go && (bidx_q == '0);
        if (have_word) begin
          sym_o.k = ~be_sh[0];
          sym_o.d = be_sh[0] ? word_sh[7:0] : K_MASK;
          if (go) begin
            if (bidx_q == '0) begin
              word_d = wdat_data;
              be_d   = wdat_be;
            end
            if (last_d) begin
              bidx_d = '0;
              if (wcnt_q == nwm1_q) begin
                st_d = S_EOP;
              end else begin
                wcnt_d = wcnt_q + 1'b1;
              end
            end else begin
              bidx_d = bidx_q + 1'b1;
            end
          end
        end
      end
      S_EOP: begin
        sym_o.k = 1'b1;
        sym_o.d = K_EOP;
        if (go) begin
          st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      nwm1_q <= '0;
      wcnt_q <= '0;
      bidx_q <= '0;
      word_q <= '0;
      be_q   <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      nwm1_q <= nwm1_d;
      wcnt_q <= wcnt_d;
      bidx_q <= bidx_d;
      word_q <= word_d;
      be_q   <= be_d;
    end
  end

  AST_CMD_OPENS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (st_q != S_IDLE));  // R3

  AST_WORD_INSIDE_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat_valid && wdat_ready) |=> (st_q == S_DATA || st_q == S_EOP));  // R5

endmodule

// File: rtl/lnk_tx_framer.sv
module lnk_tx_framer
  import tx_link_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [LEN_W-1:0]    cmd_nwords_m1,
  input  logic                wdat_valid,
  output logic                wdat_ready,
  input  logic [DATA_W-1:0]   wdat_data,
  input  logic [DATA_W/8-1:0] wdat_be,
  input  logic                rmt_hold,
  input  logic                loc_full,
  output logic                sym_valid,
  input  logic                sym_ready,
  output logic [7:0]          sym_data,
  output logic                sym_is_k
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  logic vld_q;
  sym_t out_q;
  sym_t nxt_sym;
  sym_t fc_sym;
  sym_t seq_sym;
  logic slot;
  logic fc_req;
  logic seq_go;
  logic fc_take;

  // a new symbol is loaded whenever the output register is empty or drained
  assign slot    = rst_n_i && (!vld_q || sym_ready);
  assign fc_take = slot;
  assign seq_go  = slot && !fc_req && !rmt_hold;

  tx_fc_notify u_fc (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .loc_full (loc_full),
    .take     (fc_take),
    .req      (fc_req),
    .sym_o    (fc_sym)
  );

  tx_pkt_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .go         (seq_go),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_addr   (cmd_addr),
    .cmd_nwm1   (cmd_nwords_m1),
    .wdat_valid (wdat_valid),
    .wdat_ready (wdat_ready),
    .wdat_data  (wdat_data),
    .wdat_be    (wdat_be),
    .sym_o      (seq_sym)
  );

  // priority: flow-control notice, then hold (idle), then packet sequencer
  always_comb begin
    if (fc_req) begin
      nxt_sym = fc_sym;
    end else if (rmt_hold) begin
      nxt_sym.k = 1'b1;
      nxt_sym.d = K_IDLE;
    end else begin
      nxt_sym = seq_sym;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      vld_q   <= 1'b0;
      out_q.k <= 1'b1;
      out_q.d <= K_IDLE;
    end else if (slot) begin
      vld_q <= 1'b1;
      out_q <= nxt_sym;
    end
  end

  assign sym_valid = vld_q;
  assign sym_data  = out_q.d;
  assign sym_is_k  = out_q.k;

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sym_valid && !sym_ready) |=> ($stable(sym_data) && $stable(sym_is_k)));  // R8

  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n_i)
    sym_valid |=> sym_valid);  // R2

  AST_HOLD_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n_i)
    rmt_hold |-> (!cmd_ready && !wdat_ready));  // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rmt_hold && slot && !fc_req) |=> (sym_is_k && sym_data == K_IDLE));  // R9

  AST_FC_FIRST: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fc_req && slot) |=> (sym_is_k && (sym_data == K_FCON || sym_data == K_FCOFF)));  // R12

endmodule

// File: tb/lnk_tx_framer_bench.sv
`timescale 1ns/1ps
module lnk_tx_framer_bench;

  localparam int NPKT = 16;
  localparam int NP1  = 12;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [31:0] cmd_addr;
  logic [5:0]  cmd_nwords_m1;
  logic        wdat_valid;
  logic        wdat_ready;
  logic [31:0] wdat_data;
  logic [3:0]  wdat_be;
  logic        rmt_hold;
  logic        loc_full;
  logic        sym_valid;
  logic        sym_ready;
  logic [7:0]  sym_data;
  logic        sym_is_k;

  lnk_tx_framer u_lnk_tx_framer (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_addr      (cmd_addr),
    .cmd_nwords_m1 (cmd_nwords_m1),
    .wdat_valid    (wdat_valid),
    .wdat_ready    (wdat_ready),
    .wdat_data     (wdat_data),
    .wdat_be       (wdat_be),
    .rmt_hold      (rmt_hold),
    .loc_full      (loc_full),
    .sym_valid     (sym_valid),
    .sym_ready     (sym_ready),
    .sym_data      (sym_data),
    .sym_is_k      (sym_is_k)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total;
  int bad;

  logic [8:0] exp_sym [0:1023];
  int         exp_req [0:1023];
  int         pkt_ofs [0:NPKT];
  int         exp_n;

  function automatic int f_nw(int p);
    return (p % 8) + 1;
  endfunction

  function automatic logic [31:0] f_addr(int p);
    return 32'h1000_0000 + 32'(p) * 32'h0011_0104;
  endfunction

  function automatic logic [31:0] f_data(int p, int w);
    return 32'hC0DE_0000 ^ (32'(p) << 20) ^ (32'(w) * 32'h0103_0507);
  endfunction

  function automatic logic [3:0] f_be(int p, int w);
    return 4'((p * 5 + w * 3 + 15) % 16);
  endfunction

  task automatic put(input logic k, input logic [7:0] d, input int r);
    exp_sym[exp_n] = {k, d};
    exp_req[exp_n] = r;
    exp_n++;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected symbol stream, built from the requirements
  task automatic build_stream();
    exp_n = 0;
    for (int p = 0; p < NPKT; p++) begin
      logic [31:0] a;
      pkt_ofs[p] = exp_n;
      a = f_addr(p);
      if (f_nw(p) == 1) put(1'b0, 8'h30, 3);                    // R3 single word type
      else begin
        put(1'b0, 8'h10, 3);                                     // R3 incrementing type
        put(1'b0, 8'(f_nw(p) * 4 - 1), 3);                       // R3 byte count
      end
      for (int b = 3; b >= 0; b--) put(1'b0, a[b*8 +: 8], 4);   // R4
      for (int w = 0; w < f_nw(p); w++) begin
        logic [31:0] dw;
        logic [3:0]  be;
        dw = f_data(p, w);
        be = f_be(p, w);
        for (int b = 3; b >= 0; b--) begin
          if (be[b]) put(1'b0, dw[b*8 +: 8], 5);                 // R5
          else       put(1'b1, 8'hF7, 6);                        // R6
        end
      end
      put(1'b1, 8'hFD, 7);                                       // R7
    end
    pkt_ofs[NPKT] = exp_n;
  endtask

  initial begin
    int   cyc;
    int   phase;
    int   p3;
    int   lim;
    int   pk;
    int   wd_p;
    int   wd_w;
    int   got_n;
    int   fc_on1, fc_off1, fc_on3, fc_off3;
    bit   prev_stall;
    logic [8:0] prev_sym;
    bit   hold_prev;
    bit   done;

    total = 0; bad = 0;
    build_stream();
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_addr = '0; cmd_nwords_m1 = '0;
    wdat_valid = 1'b0; wdat_data = '0; wdat_be = '0;
    rmt_hold = 1'b0; loc_full = 1'b0; sym_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    sym_ready = 1'b1;
    #0.1;
    // R1: nothing offered or taken in reset
    check(sym_valid == 1'b0 && cmd_ready == 1'b0 && wdat_ready == 1'b0, "R1",
          {sym_valid, cmd_ready, wdat_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R2: idle after reset with nothing queued
    check(sym_valid && sym_is_k && sym_data == 8'hBC, "R2", {sym_is_k, sym_data}, 9'h1BC);

    cyc = 0; phase = 1; p3 = 0; lim = NP1;
    pk = 0; wd_p = 0; wd_w = 0; got_n = 0;
    fc_on1 = 0; fc_off1 = 0; fc_on3 = 0; fc_off3 = 0;
    prev_stall = 1'b0; prev_sym = '0; hold_prev = 1'b0; done = 1'b0;

    while (!done) begin
      @(negedge clk);
      cyc++;
      // R8: a refused symbol is still there one cycle later
      if (prev_stall) begin
        check({sym_is_k, sym_data} == prev_sym, "R8", {sym_is_k, sym_data}, prev_sym);
      end
      hold_prev = rmt_hold;

      if (phase == 1 && got_n == pkt_ofs[NP1]) begin phase = 2; lim = NPKT; end
      if (phase == 2 && got_n == exp_n) phase = 3;
      if (phase == 3) p3++;

      sym_ready = (phase == 1) ? (((cyc * 7) % 5) != 0) : 1'b1;
      rmt_hold  = (phase == 2) ? ((cyc % 7) < 3) : 1'b0;
      if (phase == 1) loc_full = (cyc >= 30 && cyc < 34) || (cyc >= 120 && cyc < 126);
      else if (phase == 3) loc_full = (p3 >= 6 && p3 < 21);
      else loc_full = 1'b0;

      cmd_valid     = (pk < lim);
      cmd_addr      = f_addr(pk);
      cmd_nwords_m1 = 6'(f_nw(pk) - 1);
      // R11: odd packets see gaps in the data queue
      wdat_valid = (wd_p < lim) && ((wd_p % 2 == 0) || (cyc % 3 != 0));
      wdat_data  = f_data(wd_p, wd_w);
      wdat_be    = f_be(wd_p, wd_w);
      #1;

      if (sym_valid && sym_ready) begin
        if (hold_prev) begin
          // R9: under hold only idle or flow-control symbols leave
          check(sym_is_k && (sym_data == 8'hBC || sym_data == 8'h1C || sym_data == 8'h7C),
                "R9", {sym_is_k, sym_data}, 9'h1BC);
        end
        if (phase == 3 && p3 <= 5) begin
          // R2: idle between traffic; R7: nothing after the last end symbol
          check(sym_is_k && sym_data == 8'hBC, "R2", {sym_is_k, sym_data}, 9'h1BC);
        end
        if (sym_is_k && sym_data == 8'hBC) begin
        end else if (sym_is_k && sym_data == 8'h1C) begin
          if (phase == 3) fc_on3++; else fc_on1++;
        end else if (sym_is_k && sym_data == 8'h7C) begin
          if (phase == 3) fc_off3++; else fc_off1++;
        end else if (got_n < exp_n) begin
          if ({sym_is_k, sym_data} != exp_sym[got_n]) begin
            check(1'b0, $sformatf("R%0d sym %0d", exp_req[got_n], got_n),
                  {sym_is_k, sym_data}, exp_sym[got_n]);
          end else begin
            total++;
          end
          got_n++;
        end else begin
          check(1'b0, "R7 extra symbol", {sym_is_k, sym_data}, 9'h1BC);
        end
      end
      if (cmd_valid && cmd_ready) pk++;
      if (wdat_valid && wdat_ready) begin
        if (wd_w + 1 == f_nw(wd_p)) begin wd_p++; wd_w = 0; end
        else wd_w++;
      end
      prev_stall = sym_valid && !sym_ready;
      prev_sym   = {sym_is_k, sym_data};

      if (phase == 3 && p3 >= 40) done = 1'b1;
      if (cyc > 20000) begin
        check(1'b0, "watchdog", cyc, 20000);
        done = 1'b1;
      end
    end

    check(got_n == exp_n, "R7 stream length", got_n, exp_n);
    check(wd_p == NPKT && pk == NPKT, "R11 all words taken", wd_p, NPKT);
    check(fc_on1 == 2 && fc_off1 == 2, "R12 notices during traffic", fc_on1 * 16 + fc_off1, 8'h22);
    check(fc_on3 == 1, "R10 start notice", fc_on3, 1);
    check(fc_off3 == 1, "R10 stop notice", fc_off3, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule